// File: doc/BRIEF.md
# Count-Driven Serial Master Sequencer

This block is the control and sequencing core of a serial bus master that uses 7-bit target addresses. Software programs a control word, a target address and a byte count through a small write port. A start request launches a transfer. The block sends the address phase to a bit-level bus engine, then moves bytes between an external packing buffer and the engine. It stops when the working count runs out or when a byte is not acknowledged. At that point it either issues a stop condition or keeps the bus and raises access-ready, so that software can follow with a repeated start. A repeat mode ignores the count and streams bytes until software requests a stop.

The engine interface is a valid/ready command channel with four command types: START carries an address byte, WRITE carries a data byte, READ asks for a byte, and STOP releases the bus. Every accepted command gets exactly one response pulse, which carries an ack/NACK flag and, for reads, a byte. The sequencer has nine named states. IDLE waits for a launch. ADDR drives START and AWAIT collects its response. MOVE decides the next step. XCMD drives WRITE or READ and XWAIT collects its response. STOP drives STOP and SWAIT collects its response. HOLD keeps the bus after access-ready or a data NACK. The transitions are: IDLE→ADDR and HOLD→ADDR on launch; ADDR→AWAIT, XCMD→XWAIT and STOP→SWAIT on handshake; AWAIT→MOVE on address ack and AWAIT→IDLE on address NACK; MOVE→XCMD when data or space is present; MOVE→STOP on count exhausted with stop set, or on stop in repeat mode; MOVE→HOLD on count exhausted with stop clear; XWAIT→MOVE on a normal response and XWAIT→HOLD on a write NACK; HOLD→STOP when stop is written; SWAIT→IDLE. Disabling the controller returns it to IDLE from any state.

Top module: `csm_top`

## Requirements
- R1: A control write stores only the bits set in 0xCF87. Bit 15 is enable, bit 10 is master, bit 9 is transmit (1 means write), bit 8 is extended addressing, bit 2 is repeat, bit 1 is stop and bit 0 is start. `ctrl_o` returns the stored value.
- R2: A control write from IDLE or HOLD with enable, master and start set and extended addressing clear launches a transfer. It issues one START command (`cmd_type_o`=0) whose byte is {address[6:0], inverse of transmit}. The start bit reads back as 0, and `buf_clear_o` pulses for one cycle in the cycle after the write.
- R3: A control write with master clear or extended addressing set is stored as written (after the mask) but issues no command, and `busy_o` stays 0.
- R4: On an acknowledged address, `count_o` (the working count) loads the count register. On a NACKed address, `nack_o` sets, the stop bit clears, no further command is issued and the block returns to idle.
- R5: In counted mode each data response decrements `count_o` by one. A transmit issues WRITE (`cmd_type_o`=1) with `tx_byte_i` and pulses `tx_pop_o`. A receive issues READ (`cmd_type_o`=2), and the cycle after the response `rx_push_o` pulses with the received byte on `rx_byte_o`.
- R6: When the count is exhausted with stop set, one STOP command (`cmd_type_o`=3) is issued. After its response the stop bit clears, `count_o` reloads from the count register, `tx_flush_o` pulses and `busy_o` falls.
- R7: When the count is exhausted with stop clear, `ardy_o` sets and the master bit clears. The bus stays held (`busy_o`=1, no STOP), and a later launch issues a repeated START.
- R8: `txrdy_o` is high while a counted transmit waits for data with count remaining, and is low once the count is exhausted or the transfer has ended.
- R9: In repeat mode the count is neither checked nor decremented. Bytes move while data or space is present, and writing stop ends the transfer with STOP after the current byte.
- R10: A NACK on a written byte sets `nack_o`, clears the stop bit and stops data movement with the bus held. Writing stop afterwards issues STOP.
- R11: A control write with enable clear returns the block to idle and clears the status flags, the working count, the address and the count register.
- R12: A write to the status select clears `nack_o` where data bit 1 is 1 and `ardy_o` where data bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 address, 2 count, 3 status clear |
| wr_data | input | 16 | Write data |
| ctrl_o | output | 16 | Stored control word |
| count_o | output | CNT_W | Working byte count |
| busy_o | output | 1 | Sequencer not idle (bus owned) |
| nack_o | output | 1 | NACK status flag |
| ardy_o | output | 1 | Access-ready status flag |
| txrdy_o | output | 1 | Transmit waiting for data |
| buf_clear_o | output | 1 | Pulse: clear packing buffer on launch |
| tx_avail_i | input | 1 | Packing buffer holds a byte to send |
| tx_byte_i | input | 8 | Next byte to send |
| tx_pop_o | output | 1 | Byte taken from packing buffer |
| tx_flush_o | output | 1 | Pulse: empty transmit buffer after stop |
| rx_space_i | input | 1 | Packing buffer can take a byte |
| rx_push_o | output | 1 | Received byte valid |
| rx_byte_o | output | 8 | Received byte |
| cmd_valid_o | output | 1 | Engine command valid |
| cmd_ready_i | input | 1 | Engine accepts command |
| cmd_type_o | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_byte_o | output | 8 | Address or data byte |
| rsp_valid_i | input | 1 | Engine response pulse |
| rsp_nack_i | input | 1 | Response was not acknowledged |
| rsp_byte_i | input | 8 | Byte read from bus |

## Verification
The hardest cases to reach are the ones where software acts while the bus is held or a transfer is mid-stream. Examples are a stop written during a repeat-mode stream, a repeated start issued from the held state, and a NACK on a middle data byte. The bench reaches them with an engine model that can NACK the address or any chosen write. It also sets how many bytes the packing buffer holds and whether it has space, which parks the sequencer in its deciding state for as long as needed. The control writes are then made at those points.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
package csm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AWAIT, ST_MOVE, ST_XCMD,
        ST_XWAIT, ST_STOP, ST_SWAIT, ST_HOLD
    } state_t;

    typedef enum logic [1:0] {
        CMD_START = 2'd0, CMD_WRITE = 2'd1, CMD_READ = 2'd2, CMD_STOP = 2'd3
    } cmd_t;

    localparam logic [15:0] CTRL_MASK = 16'hCF87;
    localparam int B_EN  = 15;
    localparam int B_MST = 10;
    localparam int B_TX  = 9;
    localparam int B_EXT = 8;
    localparam int B_RPT = 2;
    localparam int B_STP = 1;
    localparam int B_STT = 0;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;
endpackage

// File: rtl/csm_regs.sv
`timescale 1ns/1ps
module csm_regs
    import csm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    input  logic             can_launch,
    input  logic             ev_addr_nack,
    input  logic             ev_data_nack,
    input  logic             ev_stop_done,
    input  logic             ev_hold,
    output logic [15:0]      ctrl_q,
    output logic [6:0]       addr_q,
    output logic [CNT_W-1:0] count_q,
    output logic             nack_q,
    output logic             ardy_q,
    output logic             launch,
    output logic             soft_rst
);
    logic        wr_ctrl, wr_stat;
    logic [15:0] ctrl_n;

    assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
    assign wr_stat  = wr_en && (wr_sel == SEL_STAT);
    assign soft_rst = wr_ctrl && !wr_data[B_EN];
    assign launch   = wr_ctrl && wr_data[B_EN] && wr_data[B_MST] &&
                      !wr_data[B_EXT] && wr_data[B_STT] && can_launch;

    always_comb begin
        ctrl_n = wr_ctrl ? (wr_data & CTRL_MASK) : ctrl_q;
        if (launch)
            ctrl_n[B_STT] = 1'b0;
        if (ev_addr_nack || ev_data_nack || ev_stop_done)
            ctrl_n[B_STP] = 1'b0;
        if (ev_hold)
            ctrl_n[B_MST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            addr_q  <= '0;
            count_q <= '0;
            nack_q  <= 1'b0;
            ardy_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_n;
            if (soft_rst) begin
                addr_q  <= '0;
                count_q <= '0;
                nack_q  <= 1'b0;
                ardy_q  <= 1'b0;
            end else begin
                if (wr_en && wr_sel == SEL_ADDR)
                    addr_q <= wr_data[6:0];
                if (wr_en && wr_sel == SEL_COUNT)
                    count_q <= wr_data[CNT_W-1:0];
                nack_q <= (nack_q && !(wr_stat && wr_data[1])) ||
                          ev_addr_nack || ev_data_nack;
                ardy_q <= (ardy_q && !(wr_stat && wr_data[2])) || ev_hold;
            end
        end
    end

    p_launch_clears_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ctrl_q[B_STT]);

    p_nack_clears_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> !ctrl_q[B_STP]);

    p_ctrl_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == 16'h0);
endmodule

// File: rtl/csm_wcount.sv
`timescale 1ns/1ps
module csm_wcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero
);
    assign zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && !zero)
            cnt_q <= cnt_q - 1'b1;
    end

    p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/csm_fsm.sv
`timescale 1ns/1ps
module csm_fsm
    import csm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       launch,
    input  logic       c_tx,
    input  logic       c_rpt,
    input  logic       c_stp,
    input  logic [6:0] addr,
    input  logic       cnt_zero,
    input  logic       tx_avail,
    input  logic [7:0] tx_byte,
    input  logic       rx_space,
    input  logic       cmd_ready,
    input  logic       rsp_valid,
    input  logic       rsp_nack,
    output logic       cmd_valid,
    output cmd_t       cmd_type,
    output logic [7:0] cmd_byte,
    output logic       tx_pop,
    output logic       ev_addr_nack,
    output logic       ev_load,
    output logic       ev_data,
    output logic       ev_rx,
    output logic       ev_data_nack,
    output logic       ev_stop_done,
    output logic       ev_hold,
    output logic       can_launch,
    output logic       busy,
    output logic       txrdy
);
    state_t st, nxt;
    logic   data_ok;

    assign data_ok    = c_tx ? tx_avail : rx_space;
    assign can_launch = (st == ST_IDLE) || (st == ST_HOLD);
    assign busy       = (st != ST_IDLE);
    assign txrdy      = (st == ST_MOVE) && c_tx && (c_rpt || !cnt_zero);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else if (soft_rst)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt          = st;
        cmd_valid    = 1'b0;
        cmd_type     = CMD_START;
        cmd_byte     = 8'h00;
        tx_pop       = 1'b0;
        ev_addr_nack = 1'b0;
        ev_load      = 1'b0;
        ev_data      = 1'b0;
        ev_rx        = 1'b0;
        ev_data_nack = 1'b0;
        ev_stop_done = 1'b0;
        ev_hold      = 1'b0;
        unique case (st)
            ST_IDLE: if (launch) nxt = ST_ADDR;
            ST_ADDR: begin
                cmd_valid = 1'b1;
                cmd_type  = CMD_START;
                cmd_byte  = {addr, !c_tx};
                if (cmd_ready) nxt = ST_AWAIT;
            end
            ST_AWAIT: if (rsp_valid) begin
                if (rsp_nack) begin
                    ev_addr_nack = 1'b1;
                    nxt          = ST_IDLE;
                end else begin
                    ev_load = 1'b1;
                    nxt     = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (c_rpt) begin
                    if (c_stp)        nxt = ST_STOP;
                    else if (data_ok) nxt = ST_XCMD;
                end else if (cnt_zero) begin
                    if (c_stp) nxt = ST_STOP;
                    else begin
                        ev_hold = 1'b1;
                        nxt     = ST_HOLD;
                    end
                end else if (data_ok) begin
                    nxt = ST_XCMD;
                end
            end
            ST_XCMD: begin
                cmd_valid = 1'b1;
                cmd_type  = c_tx ? CMD_WRITE : CMD_READ;
                cmd_byte  = c_tx ? tx_byte : 8'h00;
                if (cmd_ready) begin
                    tx_pop = c_tx;
                    nxt    = ST_XWAIT;
                end
            end
            ST_XWAIT: if (rsp_valid) begin
                ev_data = 1'b1;
                ev_rx   = !c_tx;
                if (c_tx && rsp_nack) begin
                    ev_data_nack = 1'b1;
                    nxt          = ST_HOLD;
                end else begin
                    nxt = ST_MOVE;
                end
            end
            ST_STOP: begin
                cmd_valid = 1'b1;
                cmd_type  = CMD_STOP;
                if (cmd_ready) nxt = ST_SWAIT;
            end
            ST_SWAIT: if (rsp_valid) begin
                ev_stop_done = 1'b1;
                nxt          = ST_IDLE;
            end
            ST_HOLD: begin
                if (launch)     nxt = ST_ADDR;
                else if (c_stp) nxt = ST_STOP;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !soft_rst && $stable(c_tx)) |=>
        (cmd_valid && $stable(cmd_type)));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !cmd_valid);
endmodule

// File: rtl/csm_top.sv
`timescale 1ns/1ps
module csm_top
    import csm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic [15:0]      ctrl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             nack_o,
    output logic             ardy_o,
    output logic             txrdy_o,
    output logic             buf_clear_o,
    input  logic             tx_avail_i,
    input  logic [7:0]       tx_byte_i,
    output logic             tx_pop_o,
    output logic             tx_flush_o,
    input  logic             rx_space_i,
    output logic             rx_push_o,
    output logic [7:0]       rx_byte_o,
    output logic             cmd_valid_o,
    input  logic             cmd_ready_i,
    output logic [1:0]       cmd_type_o,
    output logic [7:0]       cmd_byte_o,
    input  logic             rsp_valid_i,
    input  logic             rsp_nack_i,
    input  logic [7:0]       rsp_byte_i
);
    logic [15:0]      ctrl_q;
    logic [6:0]       addr_q;
    logic [CNT_W-1:0] count_q;
    logic launch, soft_rst, can_launch, cnt_zero;
    logic ev_addr_nack, ev_load, ev_data, ev_rx, ev_data_nack, ev_stop_done, ev_hold;
    cmd_t cmd_type;

    csm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .can_launch(can_launch), .ev_addr_nack(ev_addr_nack), .ev_data_nack(ev_data_nack),
        .ev_stop_done(ev_stop_done), .ev_hold(ev_hold), .ctrl_q(ctrl_q), .addr_q(addr_q),
        .count_q(count_q), .nack_q(nack_o), .ardy_q(ardy_o), .launch(launch),
        .soft_rst(soft_rst)
    );

    csm_wcount #(.CNT_W(CNT_W)) u_wcount (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(ev_load || ev_stop_done),
        .load_val(count_q), .dec(ev_data && !ctrl_q[B_RPT]), .cnt_q(count_o),
        .zero(cnt_zero)
    );

    csm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .launch(launch),
        .c_tx(ctrl_q[B_TX]), .c_rpt(ctrl_q[B_RPT]), .c_stp(ctrl_q[B_STP]),
        .addr(addr_q), .cnt_zero(cnt_zero), .tx_avail(tx_avail_i), .tx_byte(tx_byte_i),
        .rx_space(rx_space_i), .cmd_ready(cmd_ready_i), .rsp_valid(rsp_valid_i),
        .rsp_nack(rsp_nack_i), .cmd_valid(cmd_valid_o), .cmd_type(cmd_type),
        .cmd_byte(cmd_byte_o), .tx_pop(tx_pop_o), .ev_addr_nack(ev_addr_nack),
        .ev_load(ev_load), .ev_data(ev_data), .ev_rx(ev_rx), .ev_data_nack(ev_data_nack),
        .ev_stop_done(ev_stop_done), .ev_hold(ev_hold), .can_launch(can_launch),
        .busy(busy_o), .txrdy(txrdy_o)
    );

    assign ctrl_o     = ctrl_q;
    assign cmd_type_o = cmd_type;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_clear_o <= 1'b0;
            tx_flush_o  <= 1'b0;
            rx_push_o   <= 1'b0;
            rx_byte_o   <= 8'h00;
        end else begin
            buf_clear_o <= launch;
            tx_flush_o  <= ev_stop_done;
            rx_push_o   <= ev_rx;
            if (ev_rx)
                rx_byte_o <= rsp_byte_i;
        end
    end

    p_ardy_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ardy_o) |-> (count_o == '0) && !ctrl_q[B_MST] && busy_o);

    p_txrdy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txrdy_o && !ctrl_q[B_RPT]) |-> (count_o != '0));

    p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy_o && count_o == '0 && !nack_o && !ardy_o));
endmodule

// File: tb/csm_top_bench.sv
`timescale 1ns/1ps
module csm_top_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] ctrl_o;
    logic [CNT_W-1:0] count_o;
    logic busy_o, nack_o, ardy_o, txrdy_o, buf_clear_o, tx_pop_o, tx_flush_o;
    logic rx_push_o, cmd_valid_o;
    logic [7:0] rx_byte_o, cmd_byte_o;
    logic [1:0] cmd_type_o;
    logic tx_avail_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h10;
    logic rx_space_i = 1'b0;
    logic cmd_ready_i = 1'b1;
    logic rsp_valid_i = 1'b0;
    logic rsp_nack_i = 1'b0;
    logic [7:0] rsp_byte_i = 8'h00;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    int n_cmd, n_wr, n_rd, n_rx, n_flush, n_clr, tx_have, nack_at;
    bit addr_nack;
    logic [1:0] log_t [0:31];
    logic [7:0] log_b [0:31];
    logic [7:0] rx_seen [0:31];
    bit pend, pend_nack;
    logic [7:0] pend_byte;

    csm_top #(.CNT_W(CNT_W)) u_csm_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_o(ctrl_o), .count_o(count_o), .busy_o(busy_o), .nack_o(nack_o),
        .ardy_o(ardy_o), .txrdy_o(txrdy_o), .buf_clear_o(buf_clear_o),
        .tx_avail_i(tx_avail_i), .tx_byte_i(tx_byte_i), .tx_pop_o(tx_pop_o),
        .tx_flush_o(tx_flush_o), .rx_space_i(rx_space_i), .rx_push_o(rx_push_o),
        .rx_byte_o(rx_byte_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_type_o(cmd_type_o), .cmd_byte_o(cmd_byte_o), .rsp_valid_i(rsp_valid_i),
        .rsp_nack_i(rsp_nack_i), .rsp_byte_i(rsp_byte_i)
    );

    always #5 clk = ~clk;

    // Engine and buffer model, all driven at the falling edge.
    always @(negedge clk) begin
        rsp_valid_i = pend;
        rsp_nack_i  = pend_nack;
        rsp_byte_i  = pend_byte;
        pend = 0;
        if (rx_push_o) begin
            rx_seen[n_rx[4:0]] = rx_byte_o;
            n_rx++;
        end
        if (tx_flush_o)  n_flush++;
        if (buf_clear_o) n_clr++;
        if (cmd_valid_o && cmd_ready_i) begin
            log_t[n_cmd[4:0]] = cmd_type_o;
            log_b[n_cmd[4:0]] = cmd_byte_o;
            n_cmd++;
            pend = 1;
            pend_nack = 0;
            pend_byte = 8'h00;
            case (cmd_type_o)
                2'd0: pend_nack = addr_nack;
                2'd1: begin
                    pend_nack = (n_wr == nack_at);
                    n_wr++;
                    if (tx_have > 0) tx_have--;
                end
                2'd2: begin
                    pend_byte = 8'hA0 + 8'(n_rd);
                    n_rd++;
                end
                default: ;
            endcase
        end
        tx_avail_i = (tx_have > 0);
        tx_byte_i  = 8'h10 + 8'(n_wr);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        #1;
    endtask

    task automatic fresh();
        @(posedge clk); #1;
        n_cmd = 0; n_wr = 0; n_rd = 0; n_rx = 0; n_flush = 0; n_clr = 0;
        tx_have = 0; nack_at = 99; addr_nack = 0; rx_space_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset ctrl", ctrl_o, 0);
        chk("R11 reset busy", busy_o, 0);
        chk("R11 reset count", count_o, 0);
        chk("R11 reset flags", {nack_o, ardy_o, cmd_valid_o}, 0);
    endtask

    task automatic t_mask();
        fresh();
        wr(2'd1, 16'h002A);
        wr(2'd0, 16'hFFFF);
        cycles(6);
        chk("R1 masked readback", ctrl_o, 16'hCF87);
        chk("R3 extended addr: no command", n_cmd, 0);
        chk("R3 extended addr: not busy", busy_o, 0);
        wr(2'd0, 16'h8001);
        cycles(6);
        chk("R3 master clear stored", ctrl_o, 16'h8001);
        chk("R3 master clear: no command", n_cmd, 0);
    endtask

    task automatic t_tx_stop();
        fresh();
        wr(2'd1, 16'h002A);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h8603);
        cycles(6);
        chk("R2 start cmd type", log_t[0], 0);
        chk("R2 start cmd byte", log_b[0], 8'h54);
        chk("R2 start bit cleared", ctrl_o, 16'h8602);
        chk("R2 buffer clear pulse", n_clr, 1);
        chk("R4 count loaded", count_o, 3);
        chk("R8 txrdy while waiting", txrdy_o, 1);
        tx_have = 1;
        cycles(8);
        chk("R5 decrement after byte", count_o, 2);
        chk("R5 write byte", {log_t[1], log_b[1]}, {2'd1, 8'h10});
        tx_have = 2;
        wait_idle();
        chk("R6 command count", n_cmd, 5);
        chk("R5 last write byte", log_b[3], 8'h12);
        chk("R6 stop issued", log_t[4], 3);
        chk("R6 stop bit cleared", ctrl_o, 16'h8600);
        chk("R6 count reloaded", count_o, 3);
        chk("R6 flush pulse", n_flush, 1);
        chk("R8 txrdy low after end", txrdy_o, 0);
    endtask

    task automatic t_rx_hold();
        fresh();
        rx_space_i = 1'b1;
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h8401);
        cycles(20);
        chk("R2 read address byte", log_b[0], 8'h55);
        chk("R5 read commands", n_rd, 2);
        chk("R5 rx pushes", n_rx, 2);
        chk("R5 rx bytes", {rx_seen[0], rx_seen[1]}, 16'hA0A1);
        chk("R7 ardy set", ardy_o, 1);
        chk("R7 master cleared", ctrl_o, 16'h8000);
        chk("R7 bus held", busy_o, 1);
        chk("R7 no stop", n_cmd, 3);
        n_cmd = 0;
        tx_have = 1;
        wr(2'd2, 16'd1);
        wr(2'd0, 16'h8603);
        wait_idle();
        chk("R7 repeated start", {log_t[0], log_b[0]}, {2'd0, 8'h54});
        chk("R7 then write and stop", {log_t[1], log_t[2]}, {2'd1, 2'd3});
        wr(2'd3, 16'h0004);
        cycles(1);
        chk("R12 ardy cleared", ardy_o, 0);
    endtask

    task automatic t_addr_nack();
        fresh();
        addr_nack = 1;
        wr(2'd2, 16'd2);
        wr(2'd0, 16'h8603);
        cycles(10);
        chk("R4 nack flag", nack_o, 1);
        chk("R4 stop cleared", ctrl_o, 16'h8600);
        chk("R4 idle after nack", busy_o, 0);
        chk("R4 only start", n_cmd, 1);
        wr(2'd3, 16'h0002);
        cycles(1);
        chk("R12 nack cleared", nack_o, 0);
    endtask

    task automatic t_data_nack();
        fresh();
        nack_at = 1;
        tx_have = 4;
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h8603);
        cycles(30);
        chk("R10 nack flag", nack_o, 1);
        chk("R10 stop cleared", ctrl_o, 16'h8600);
        chk("R10 writes stopped", n_wr, 2);
        chk("R10 bus held", busy_o, 1);
        chk("R5 count after two", count_o, 2);
        wr(2'd0, 16'h8602);
        wait_idle();
        chk("R10 stop after write", log_t[3], 3);
    endtask

    task automatic t_repeat();
        fresh();
        tx_have = 5;
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h8605);
        cycles(40);
        chk("R9 bytes beyond count", n_wr, 5);
        chk("R9 count untouched", count_o, 0);
        chk("R9 still busy", busy_o, 1);
        chk("R8 txrdy in repeat", txrdy_o, 1);
        wr(2'd0, 16'h8606);
        wait_idle();
        chk("R9 stop ends stream", log_t[6], 3);
        chk("R9 idle", busy_o, 0);
    endtask

    task automatic t_disable();
        fresh();
        addr_nack = 1;
        wr(2'd0, 16'h8401);
        cycles(8);
        addr_nack = 0;
        wr(2'd1, 16'h0011);
        wr(2'd2, 16'd5);
        wr(2'd0, 16'h8401);
        cycles(10);
        chk("R11 parked busy", busy_o, 1);
        chk("R11 nack before", nack_o, 1);
        wr(2'd0, 16'h0000);
        cycles(2);
        chk("R11 idle after disable", busy_o, 0);
        chk("R11 count cleared", count_o, 0);
        chk("R11 flags cleared", {nack_o, ardy_o}, 0);
        wr(2'd0, 16'h8403);
        cycles(4);
        chk("R11 address cleared", log_b[2], 8'h01);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        n_cmd = 0; n_wr = 0; n_rd = 0; n_rx = 0; n_flush = 0; n_clr = 0;
        tx_have = 0; nack_at = 99; addr_nack = 0;
        pend = 0; pend_nack = 0; pend_byte = 8'h00;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_mask();
        t_tx_stop();
        t_rx_hold();
        t_addr_nack();
        t_data_nack();
        t_repeat();
        t_disable();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule